// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits behind an HDLC deframer and decides, frame by frame, whether a received frame is kept or discarded. Frames arrive as a byte stream. A start marker travels with the first byte of a frame. An end strobe follows the last byte in a cycle of its own. A two-bit mode field and an address-width bit select one of five treatments:

- automatic or processor-handled address recognition, with a 1-byte or 2-byte address;
- transparent with high-byte recognition only;
- transparent with no recognition;
- fully transparent.

Kept bytes go to the write port of a receive FIFO, which lies outside the block. The leading header bytes are also latched into readable registers. When a frame ends, a status byte is written that describes the address match and the classification of the frame. The same status is held in a register.

Four programmable references are compared with the address bytes: two high references and two low references. Two fixed group values are also compared with the high byte. When the C/R-ignore input is set, bit 1 of the high byte is left out of every high comparison. In automatic mode, only one address pair routes a frame to automatic handling. The mode inputs must stay stable while a frame is in progress.

Top module: `hdlc_rx_addr_filter`

## Requirements
- R1: After reset, `fifo_wr` is 0 and `lo_addr_q`, `ctrl_q` and `status_q` are all 0x00.
- R2: In recognition modes with a 2-byte address (`mode` 00 or 01, `adm`=1), the first byte matches `ref_hi1`, `ref_hi2`, 0xFE or 0xFC. When several match, the priority is in that order. The winner is coded as `hi_sel` = 0, 1, 2 or 3 respectively.
- R3: With `cr_ignore`=1, bit 1 of the first address byte is excluded from every high comparison. The status C/R bit always reports bit 1 of that byte.
- R4: In 2-byte recognition, the second byte must match `ref_lo1` (`lo_sel`=0, with priority) or `ref_lo2` (`lo_sel`=1). Frames are kept only when both bytes match. The address bytes are never written to the FIFO. The second byte is latched into `lo_addr_q`. The third byte is latched into `ctrl_q`. Every byte from the third onward is written.
- R5: The auto bit is set only in `mode` 00. In 2-byte mode it requires `hi_sel`=0 and `lo_sel`=0. In 1-byte mode it is set for every kept frame.
- R6: In 1-byte recognition (`adm`=0), the first byte is compared with `ref_lo1` (command, C/R=0) and `ref_lo2` (response, C/R=1). It is latched into `lo_addr_q`. The second byte is latched into `ctrl_q`. Bytes from the second onward are written.
- R7: A frame whose address matches nothing writes nothing. It leaves `status_q`, `lo_addr_q` and `ctrl_q` unchanged.
- R8: In `mode`=10 with `adm`=1, only the first byte is checked, using the R2/R3 rules. Every later byte is written. The second byte goes to `lo_addr_q` and the third to `ctrl_q`.
- R9: In `mode`=10 with `adm`=0, every frame is kept and every byte is written. The first byte goes to `lo_addr_q`, the second to `ctrl_q`, and the status is 0x00.
- R10: In `mode`=11, every byte is written. No status byte is written, and no register changes.
- R11: On the end strobe of a kept frame (modes other than 11), one status byte is written on the next cycle and also loaded into `status_q`. Its layout is [7:6]=`hi_sel`, [5]=`lo_sel`, [4]=C/R, [3]=auto, [2:0]=0.
- R12: An end strobe that arrives before the address field is complete aborts the frame. Nothing is written.
- R13: A kept byte appears on `fifo_data` with `fifo_wr`=1 one cycle after its input cycle. A byte without `rx_sof` outside a frame is ignored. A byte presented together with `rx_eof` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_byte` is valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_eof | input | 1 | Frame-end strobe, carries no byte |
| mode | input | 2 | Treatment select (00 auto, 01 non-auto, 10 transparent, 11 fully transparent) |
| adm | input | 1 | Address width / transparent variant select |
| cr_ignore | input | 1 | Exclude bit 1 from high comparison |
| ref_hi1 | input | 8 | First high reference |
| ref_hi2 | input | 8 | Second high reference |
| ref_lo1 | input | 8 | First low reference (command in 1-byte mode) |
| ref_lo2 | input | 8 | Second low reference (response in 1-byte mode) |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 8 | FIFO write data |
| lo_addr_q | output | 8 | Latched low-address header byte |
| ctrl_q | output | 8 | Latched control header byte |
| status_q | output | 8 | Status of the last kept frame |

## Verification
The checker watches every cycle for several conditions:
- no write follows a cycle without input;
- a 2-byte-mode address byte is never written;
- transparent first bytes are forwarded one cycle later;
- a fully transparent frame end produces no write;
- a status write at frame end equals `status_q`;
- the header registers hold whenever no byte is accepted.

Some behaviour can only be shown by the bench's frame scenarios, which compare the written sequence and the registers against a model:
- which reference wins when several match, and the effect of masking the C/R bit;
- six-way pair acceptance and auto classification;
- silent drops and early aborts.

// File: rtl/hdlc_rxaf_pkg.sv
package hdlc_rxaf_pkg;
    localparam int BYTE_W = 8;

    localparam logic [1:0] MD_AUTO  = 2'b00;
    localparam logic [1:0] MD_NAUTO = 2'b01;
    localparam logic [1:0] MD_TRANS = 2'b10;
    localparam logic [1:0] MD_EXT   = 2'b11;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HUNT,
        PH_PASS,
        PH_DROP
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [1:0]          idx;
        logic [1:0]          hi_sel;
        logic                lo_sel;
        logic                cr;
        logic                auto_f;
        logic                wr;
        logic [BYTE_W-1:0]   wdat;
        logic [BYTE_W-1:0]   lo_addr;
        logic [BYTE_W-1:0]   ctrl;
        logic [BYTE_W-1:0]   stat;
    } filt_state_t;
endpackage

// File: rtl/hdlc_hi_match.sv
module hdlc_hi_match #(
    parameter int            W      = 8,
    parameter logic [W-1:0]  FIX_A  = 8'hFE,
    parameter logic [W-1:0]  FIX_B  = 8'hFC,
    parameter int            CR_BIT = 1
) (
    input  logic [W-1:0] byte_i,
    input  logic [W-1:0] ref1_i,
    input  logic [W-1:0] ref2_i,
    input  logic         cri_i,
    output logic         hit_o,
    output logic [1:0]   sel_o
);
    localparam int NCAND = 4;

    logic [W-1:0] cand [NCAND];
    logic [W-1:0] mask;
    logic [NCAND-1:0] eq;

    assign cand[0] = ref1_i;
    assign cand[1] = ref2_i;
    assign cand[2] = FIX_A;
    assign cand[3] = FIX_B;

    always_comb begin
        mask = '1;
        if (cri_i) mask[CR_BIT] = 1'b0;
    end

    for (genvar k = 0; k < NCAND; k++) begin : g_cmp
        assign eq[k] = ((byte_i ^ cand[k]) & mask) == '0;
    end

    always_comb begin
        sel_o = 2'd0;
        for (int k = NCAND - 1; k >= 0; k--) begin
            if (eq[k]) sel_o = 2'(k);
        end
    end

    assign hit_o = |eq;
endmodule

// File: rtl/hdlc_lo_match.sv
module hdlc_lo_match #(
    parameter int W = 8
) (
    input  logic [W-1:0] byte_i,
    input  logic [W-1:0] ref1_i,
    input  logic [W-1:0] ref2_i,
    output logic         hit_o,
    output logic         sel_o
);
    logic eq1, eq2;

    assign eq1   = (byte_i == ref1_i);
    assign eq2   = (byte_i == ref2_i);
    assign hit_o = eq1 | eq2;
    assign sel_o = ~eq1 & eq2;
endmodule

// File: rtl/hdlc_rx_addr_filter.sv
module hdlc_rx_addr_filter
    import hdlc_rxaf_pkg::*;
#(
    parameter logic [BYTE_W-1:0] GROUP_A = 8'hFE,
    parameter logic [BYTE_W-1:0] GROUP_B = 8'hFC,
    parameter int                CR_BIT  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [1:0]        mode,
    input  logic              adm,
    input  logic              cr_ignore,
    input  logic [BYTE_W-1:0] ref_hi1,
    input  logic [BYTE_W-1:0] ref_hi2,
    input  logic [BYTE_W-1:0] ref_lo1,
    input  logic [BYTE_W-1:0] ref_lo2,
    output logic              fifo_wr,
    output logic [BYTE_W-1:0] fifo_data,
    output logic [BYTE_W-1:0] lo_addr_q,
    output logic [BYTE_W-1:0] ctrl_q,
    output logic [BYTE_W-1:0] status_q
);
    localparam logic [1:0] IDX_MAX = 2'd3;

    filt_state_t q, d;

    logic       hi_hit, lo_hit, lo_sel_w;
    logic [1:0] hi_sel_w;
    logic [1:0] idx_c;
    phase_e     ph_c;
    logic [BYTE_W-1:0] stat_now;

    hdlc_hi_match #(.W(BYTE_W), .FIX_A(GROUP_A), .FIX_B(GROUP_B), .CR_BIT(CR_BIT)) u_hi (
        .byte_i (rx_byte),
        .ref1_i (ref_hi1),
        .ref2_i (ref_hi2),
        .cri_i  (cr_ignore),
        .hit_o  (hi_hit),
        .sel_o  (hi_sel_w)
    );

    hdlc_lo_match #(.W(BYTE_W)) u_lo (
        .byte_i (rx_byte),
        .ref1_i (ref_lo1),
        .ref2_i (ref_lo2),
        .hit_o  (lo_hit),
        .sel_o  (lo_sel_w)
    );

    assign stat_now = {q.hi_sel, q.lo_sel, q.cr, q.auto_f, 3'b000};

    always_comb begin
        d      = q;
        d.wr   = 1'b0;
        d.wdat = '0;
        idx_c  = rx_sof ? 2'd0 : q.idx;
        ph_c   = rx_sof ? PH_HUNT : q.ph;
        if (rx_eof) begin
            // Frame end: only a kept frame produces a status byte
            if (q.ph == PH_PASS && mode != MD_EXT) begin
                d.wr   = 1'b1;
                d.wdat = stat_now;
                d.stat = stat_now;
            end
            d.ph = PH_IDLE;
        end else if (rx_valid && (rx_sof || q.ph == PH_HUNT || q.ph == PH_PASS)) begin
            if (rx_sof) begin
                d.hi_sel = '0;
                d.lo_sel = 1'b0;
                d.cr     = 1'b0;
                d.auto_f = 1'b0;
            end
            d.idx = (idx_c == IDX_MAX) ? IDX_MAX : idx_c + 2'd1;
            d.ph  = ph_c;
            if (mode == MD_EXT) begin
                d.ph   = PH_PASS;
                d.wr   = 1'b1;
                d.wdat = rx_byte;
            end else if (mode == MD_TRANS && !adm) begin
                d.ph   = PH_PASS;
                d.wr   = 1'b1;
                d.wdat = rx_byte;
                if (idx_c == 2'd0) d.lo_addr = rx_byte;
                if (idx_c == 2'd1) d.ctrl    = rx_byte;
            end else if (mode == MD_TRANS) begin
                if (idx_c == 2'd0) begin
                    d.ph     = hi_hit ? PH_PASS : PH_DROP;
                    d.hi_sel = hi_sel_w;
                    d.cr     = rx_byte[CR_BIT];
                end else if (ph_c == PH_PASS) begin
                    d.wr   = 1'b1;
                    d.wdat = rx_byte;
                    if (idx_c == 2'd1) d.lo_addr = rx_byte;
                    if (idx_c == 2'd2) d.ctrl    = rx_byte;
                end
            end else if (adm) begin
                // Two-byte address recognition
                if (idx_c == 2'd0) begin
                    d.ph     = hi_hit ? PH_HUNT : PH_DROP;
                    d.hi_sel = hi_sel_w;
                    d.cr     = rx_byte[CR_BIT];
                end else if (ph_c == PH_HUNT) begin
                    d.ph = lo_hit ? PH_PASS : PH_DROP;
                    if (lo_hit) begin
                        d.lo_sel  = lo_sel_w;
                        d.lo_addr = rx_byte;
                        d.auto_f  = (mode == MD_AUTO) && (q.hi_sel == 2'd0) && !lo_sel_w;
                    end
                end else if (ph_c == PH_PASS) begin
                    d.wr   = 1'b1;
                    d.wdat = rx_byte;
                    if (idx_c == 2'd2) d.ctrl = rx_byte;
                end
            end else begin
                // One-byte address recognition
                if (idx_c == 2'd0) begin
                    d.ph = lo_hit ? PH_PASS : PH_DROP;
                    if (lo_hit) begin
                        d.lo_sel  = lo_sel_w;
                        d.cr      = lo_sel_w;
                        d.lo_addr = rx_byte;
                        d.auto_f  = (mode == MD_AUTO);
                    end
                end else if (ph_c == PH_PASS) begin
                    d.wr   = 1'b1;
                    d.wdat = rx_byte;
                    if (idx_c == 2'd1) d.ctrl = rx_byte;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{ph: PH_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign fifo_wr   = q.wr;
    assign fifo_data = q.wdat;
    assign lo_addr_q = q.lo_addr;
    assign ctrl_q    = q.ctrl;
    assign status_q  = q.stat;
endmodule

// File: rtl/hdlc_rx_addr_filter_chk.sv
module hdlc_rx_addr_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       rx_sof,
    input logic       rx_eof,
    input logic [1:0] mode,
    input logic       adm,
    input logic       fifo_wr,
    input logic [7:0] fifo_data,
    input logic [7:0] lo_addr_q,
    input logic [7:0] ctrl_q,
    input logic [7:0] status_q
);
    a_r13_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !rx_eof) |=> !fifo_wr);

    a_r4_addr_not_written: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && !rx_eof && !mode[1]) |=> !fifo_wr);

    a_r9_first_byte_forwarded: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && !rx_eof && mode[1] && (mode[0] || !adm))
        |=> (fifo_wr && fifo_data == $past(rx_byte)));

    a_r10_ext_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_eof && mode == 2'b11) |=> !fifo_wr);

    a_r11_status_copy: assert property (@(posedge clk) disable iff (!rst_n)
        rx_eof |=> (!fifo_wr || fifo_data == status_q));

    a_r13_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid || rx_eof) |=> ($stable(lo_addr_q) && $stable(ctrl_q)));
endmodule

bind hdlc_rx_addr_filter hdlc_rx_addr_filter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_byte   (rx_byte),
    .rx_valid  (rx_valid),
    .rx_sof    (rx_sof),
    .rx_eof    (rx_eof),
    .mode      (mode),
    .adm       (adm),
    .fifo_wr   (fifo_wr),
    .fifo_data (fifo_data),
    .lo_addr_q (lo_addr_q),
    .ctrl_q    (ctrl_q),
    .status_q  (status_q)
);

// File: tb/hdlc_rx_addr_filter_tb.sv
`timescale 1ns/1ps
module hdlc_rx_addr_filter_tb;
    localparam logic [7:0] RH1 = 8'h10, RH2 = 8'h24, RL1 = 8'h01, RL2 = 8'h03;

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  md;
        logic        adm;
        logic        cri;
        logic [2:0]  len;
        logic [31:0] by;
    } vec_t;

    // Tags: R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{4'd5,  2'b00, 1'b1, 1'b0, 3'd4, 32'h1001AA55}, // R5 auto pair
        '{4'd2,  2'b00, 1'b1, 1'b0, 3'd4, 32'h2401C011}, // R2 second high ref
        '{4'd2,  2'b00, 1'b1, 1'b0, 3'd4, 32'hFE032233}, // R2 group FE
        '{4'd2,  2'b01, 1'b1, 1'b0, 3'd3, 32'hFC014400}, // R2 group FC
        '{4'd5,  2'b01, 1'b1, 1'b0, 3'd3, 32'h10039900}, // R5 non-auto mode
        '{4'd3,  2'b00, 1'b1, 1'b1, 3'd4, 32'h12016677}, // R3 masked C/R
        '{4'd7,  2'b00, 1'b1, 1'b0, 3'd3, 32'h12016600}, // R7 unmasked mismatch
        '{4'd3,  2'b00, 1'b1, 1'b1, 3'd3, 32'hFC038800}, // R3 FC folds onto FE
        '{4'd7,  2'b00, 1'b1, 1'b0, 3'd3, 32'h10054400}, // R7 low mismatch
        '{4'd12, 2'b00, 1'b1, 1'b0, 3'd1, 32'h10000000}, // R12 early end
        '{4'd6,  2'b00, 1'b0, 1'b0, 3'd3, 32'h01ABCD00}, // R6 command
        '{4'd6,  2'b01, 1'b0, 1'b0, 3'd2, 32'h03EE0000}, // R6 response
        '{4'd7,  2'b00, 1'b0, 1'b0, 3'd2, 32'h02110000}, // R7 one-byte drop
        '{4'd8,  2'b10, 1'b1, 1'b0, 3'd4, 32'h24B1C2D3}, // R8 high-only
        '{4'd8,  2'b10, 1'b1, 1'b0, 3'd3, 32'h33445500}, // R8 drop
        '{4'd9,  2'b10, 1'b0, 1'b0, 3'd3, 32'h99887700}, // R9 all kept
        '{4'd10, 2'b11, 1'b0, 1'b0, 3'd3, 32'h5AA53C00}, // R10 fully transparent
        '{4'd11, 2'b10, 1'b1, 1'b1, 3'd1, 32'h26000000}  // R11 status-only frame
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] rx_byte = '0;
    logic rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [1:0] mode = '0;
    logic adm = 1'b0, cr_ignore = 1'b0;
    logic fifo_wr;
    logic [7:0] fifo_data, lo_addr_q, ctrl_q, status_q;

    int checks = 0, errors = 0;
    logic [7:0] cap [16];
    int cap_n = 0;
    logic [7:0] expv [16];
    int exp_n = 0;
    logic [7:0] m_lo = '0, m_ctrl = '0, m_stat = '0;

    always #10 clk = ~clk;

    hdlc_rx_addr_filter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .mode(mode), .adm(adm),
        .cr_ignore(cr_ignore), .ref_hi1(RH1), .ref_hi2(RH2), .ref_lo1(RL1),
        .ref_lo2(RL2), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .lo_addr_q(lo_addr_q), .ctrl_q(ctrl_q), .status_q(status_q)
    );

    always @(posedge clk) begin
        #1;
        if (fifo_wr && cap_n < 16) begin
            cap[cap_n] = fifo_data;
            cap_n++;
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic hi_look(input logic [7:0] b, input logic cri, output bit ok, output logic [1:0] sel);
        logic [7:0] m;
        m = cri ? 8'hFD : 8'hFF;
        ok = 1'b1;
        if (((b ^ RH1) & m) == 0)        sel = 2'd0;
        else if (((b ^ RH2) & m) == 0)   sel = 2'd1;
        else if (((b ^ 8'hFE) & m) == 0) sel = 2'd2;
        else if (((b ^ 8'hFC) & m) == 0) sel = 2'd3;
        else begin ok = 1'b0; sel = 2'd0; end
    endtask

    task automatic lo_look(input logic [7:0] b, output bit ok, output logic sel);
        ok  = (b == RL1) || (b == RL2);
        sel = (b != RL1);
    endtask

    task automatic push(input logic [7:0] b);
        expv[exp_n] = b;
        exp_n++;
    endtask

    task automatic model(input vec_t v);
        logic [7:0] b [4];
        bit hok, lok;
        logic [1:0] hs;
        logic ls;
        logic [7:0] st;
        int n;
        n = int'(v.len);
        exp_n = 0;
        for (int i = 0; i < 4; i++) b[i] = v.by[31-8*i -: 8];
        if (v.md == 2'b11) begin
            for (int i = 0; i < n; i++) push(b[i]);
        end else if (v.md == 2'b10 && !v.adm) begin
            for (int i = 0; i < n; i++) push(b[i]);
            m_lo = b[0];
            if (n > 1) m_ctrl = b[1];
            m_stat = 8'h00;
            push(8'h00);
        end else if (v.md == 2'b10) begin
            hi_look(b[0], v.cri, hok, hs);
            if (hok) begin
                for (int i = 1; i < n; i++) push(b[i]);
                if (n > 1) m_lo = b[1];
                if (n > 2) m_ctrl = b[2];
                st = {hs, 1'b0, b[0][1], 1'b0, 3'b000};
                m_stat = st;
                push(st);
            end
        end else if (v.adm) begin
            hi_look(b[0], v.cri, hok, hs);
            lo_look(b[1], lok, ls);
            if (n >= 2 && hok && lok) begin
                m_lo = b[1];
                if (n > 2) m_ctrl = b[2];
                for (int i = 2; i < n; i++) push(b[i]);
                st = {hs, ls, b[0][1], (v.md == 2'b00 && hs == 2'd0 && !ls), 3'b000};
                m_stat = st;
                push(st);
            end
        end else begin
            lo_look(b[0], lok, ls);
            if (lok) begin
                m_lo = b[0];
                if (n > 1) m_ctrl = b[1];
                for (int i = 1; i < n; i++) push(b[i]);
                st = {2'b00, ls, ls, (v.md == 2'b00), 3'b000};
                m_stat = st;
                push(st);
            end
        end
    endtask

    task automatic send(input vec_t v);
        mode = v.md; adm = v.adm; cr_ignore = v.cri;
        for (int i = 0; i < int'(v.len); i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (i == 0); rx_byte = v.by[31-8*i -: 8];
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b1;
        @(negedge clk);
        rx_eof = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "fifo_wr", {7'b0, fifo_wr}, 8'h00);
        chk("R1", "lo_addr", lo_addr_q, 8'h00);
        chk("R1", "ctrl", ctrl_q, 8'h00);
        chk("R1", "status", status_q, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[k].req);
            model(VECS[k]);
            cap_n = 0;
            send(VECS[k]);
            chk(tag, $sformatf("vec%0d count", k), 8'(cap_n), 8'(exp_n));
            for (int i = 0; i < exp_n && i < cap_n; i++)
                chk(tag, $sformatf("vec%0d byte%0d", k, i), cap[i], expv[i]);
            chk(tag, $sformatf("vec%0d status", k), status_q, m_stat);
            chk(tag, $sformatf("vec%0d lo_addr", k), lo_addr_q, m_lo);
            chk(tag, $sformatf("vec%0d ctrl", k), ctrl_q, m_ctrl);
        end

        // R13: stray byte outside a frame is ignored
        cap_n = 0;
        mode = 2'b10; adm = 1'b0;
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'h77;
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13", "stray count", 8'(cap_n), 8'd0);
        chk("R13", "stray lo_addr", lo_addr_q, m_lo);

        // R13: one-cycle latency, and byte alongside eof ignored
        cap_n = 0;
        mode = 2'b11;
        rx_valid = 1'b1; rx_sof = 1'b1; rx_byte = 8'h11;
        @(posedge clk);
        #1;
        chk("R13", "latency wr", {7'b0, fifo_wr}, 8'h01);
        chk("R13", "latency data", fifo_data, 8'h11);
        @(negedge clk);
        rx_sof = 1'b0; rx_byte = 8'h22; rx_eof = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rx_eof = 1'b0;
        repeat (2) @(negedge clk);
        chk("R13", "eof byte count", 8'(cap_n), 8'd1);
        chk("R10", "ext status held", status_q, m_stat);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule